// File: doc/BRIEF.md
# Early-Exit Serial Population Counter

This block counts the set bits of a parameter-wide input word one bit at a time. A one-cycle start pulse captures the word into a shift register and clears an accumulator. A small controller then alternates between a test cycle and a step cycle. The test cycle checks whether the shift register still holds any set bit. The step cycle adds the register's least significant bit to the accumulator and shifts the register right with zero fill.

The loop ends as soon as the shift register becomes zero, so the run time follows the position of the highest set bit rather than the word width. When the loop ends, the block spends one cycle in a finish state. In that cycle the done flag is raised and the count is presented, zero-extended to the word width. The block then returns to idle and can accept the next start pulse immediately.

Top module: `bitcount_seq`

## Requirements
- R1: After synchronous reset, `done` is 0 and `count_out` is 0.
- R2: While idle with `start` low, the block stays idle and `done` stays 0 for any number of cycles.
- R3: A `start` sampled high while idle captures `din` and clears the count; the reported result depends only on that captured word and never on an earlier run.
- R4: Each loop step adds bit 0 of the shift register to the count and then shifts the register right by one with zero fill, so the reported count equals the number of 1 bits in the captured word.
- R5: Let k be one plus the index of the highest set bit of the captured word, or 0 for an all-zero word. `done` rises exactly 2k+1 clock edges after the edge that sampled `start`.
- R6: An all-zero word still passes through one test and finishes with a count of 0, with `done` rising one edge after the start edge.
- R7: `done` is high for exactly one cycle per run and is 0 in every other state. The block is idle on the next cycle and accepts a new start there.
- R8: `count_out` carries the count zero-extended to the port width while `done` is high, and is 0 while `done` is low.
- R9: A `start` pulse, with any `din`, that arrives while a run is in progress has no effect on that run's result or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a count; sampled only while idle |
| din | input | WIDTH | Word whose set bits are counted |
| count_out | output | WIDTH | Zero-extended count, valid while done is high |
| done | output | 1 | High for the single finish cycle |

## Verification
The hardest case to reach from the ports is a second start pulse landing in the middle of a long run. If it were accepted, it would silently restart the count. The stimulus launches a word whose top bit is set, so the loop runs for the full width. It then pulses `start` with a different word several cycles later. The bench checks that both the latency and the count still belong to the first word. The latency rule is exercised by sweeping a single set bit across every position and requiring the exact edge count at each one.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_STEP = 2'd2,
        ST_FIN  = 2'd3
    } bc_state_t;

    typedef struct packed {
        logic load;
        logic step;
    } bc_ctrl_t;

    function automatic int unsigned count_bits_for(input int unsigned width);
        return $clog2(width + 1);
    endfunction

endpackage

// File: rtl/bitcount_ctrl.sv
module bitcount_ctrl
    import bitcount_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     data_zero,
    output bc_ctrl_t ctl,
    output logic     fin
);

    bc_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        ctl.load = 1'b0;
        ctl.step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.load = 1'b1;
                    state_d  = ST_TEST;
                end
            end
            ST_TEST: state_d = data_zero ? ST_FIN : ST_STEP;
            ST_STEP: begin
                ctl.step = 1'b1;
                state_d  = ST_TEST;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign fin = (state_q == ST_FIN);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !fin));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> (!fin && state_q == ST_IDLE));

    // R5
    fin_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TEST && data_zero) |=> fin);

endmodule

// File: rtl/bitcount_dp.sv
module bitcount_dp
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  bc_ctrl_t                              ctl,
    input  logic [WIDTH-1:0]                      din,
    output logic                                  data_zero,
    output logic [count_bits_for(WIDTH)-1:0]      cnt
);

    localparam int unsigned CW = count_bits_for(WIDTH);
    localparam logic [WIDTH-1:0] LSB_MASK = WIDTH'(1);

    logic [WIDTH-1:0] data_q;
    logic [CW-1:0]    cnt_q;
    logic             temp_bit;

    assign temp_bit  = |(data_q & LSB_MASK);
    assign data_zero = (data_q == '0);
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (ctl.load) begin
            data_q <= din;
            cnt_q  <= '0;
        end else if (ctl.step) begin
            cnt_q  <= cnt_q + CW'(temp_bit);
            data_q <= {1'b0, data_q[WIDTH-1:1]};
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(WIDTH));

    // R4
    zero_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !data_q[0]) |=> $stable(cnt_q));

    // R3
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (cnt_q == '0));

endmodule

// File: rtl/bitcount_drive.sv
module bitcount_drive #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = 5
) (
    input  logic             fin,
    input  logic [CW-1:0]    cnt,
    output logic [WIDTH-1:0] count_out
);

    logic [WIDTH-1:0] ext;

    generate
        if (WIDTH > CW) begin : g_pad
            assign ext = {{(WIDTH-CW){1'b0}}, cnt};
        end else begin : g_trim
            assign ext = cnt[WIDTH-1:0];
        end
    endgenerate

    assign count_out = fin ? ext : '0;

endmodule

// File: rtl/bitcount_seq.sv
module bitcount_seq
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count_out,
    output logic             done
);

    localparam int unsigned CW = count_bits_for(WIDTH);

    bc_ctrl_t      ctl;
    logic          data_zero;
    logic [CW-1:0] cnt;

    bitcount_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .data_zero (data_zero),
        .ctl       (ctl),
        .fin       (done)
    );

    bitcount_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .din       (din),
        .data_zero (data_zero),
        .cnt       (cnt)
    );

    bitcount_drive #(.WIDTH(WIDTH), .CW(CW)) u_drive (
        .fin       (done),
        .cnt       (cnt),
        .count_out (count_out)
    );

    // R8
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (count_out == '0));

endmodule

// File: tb/bitcount_seq_tb.sv
module bitcount_seq_tb;

    localparam int unsigned WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] count_out;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bitcount_seq #(.WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .din(din),
        .count_out(count_out), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int ref_ones(input logic [WIDTH-1:0] w);
        int n = 0;
        for (int i = 0; i < WIDTH; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int ref_span(input logic [WIDTH-1:0] w);
        int k = 0;
        for (int i = 0; i < WIDTH; i++) if (w[i]) k = i + 1;
        return k;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one word; optionally pulses start with another word mid-run.
    task automatic run_word(input logic [WIDTH-1:0] w, input bit intrude,
                            input logic [WIDTH-1:0] other, output int lat);
        int n = 0;
        @(negedge clk);
        start = 1'b1; din = w;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; din = ~w;
        while (!done && n < 4*WIDTH + 8) begin
            if (intrude && n == 3) begin start = 1'b1; din = other; end
            else if (intrude && n == 4) begin start = 1'b0; end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        lat = n;
        // R5 latency, R4 count, R8 zero-extended output
        check("R5 latency", n, 2*ref_span(w) + 1);
        check("R4 count", count_out, ref_ones(w));
        @(posedge clk);
        @(negedge clk);
        // R7 single-cycle done, R8 output quiet when done low
        check("R7 done pulse", done, 0);
        check("R8 output cleared", count_out, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 done after reset", done, 0);
        check("R1 count after reset", count_out, 0);
    endtask

    task automatic t_idle();
        bit seen = 0;
        din = '1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || count_out != 0) seen = 1;
        end
        check("R2 idle holds done low", seen, 0);
    endtask

    task automatic t_corners();
        int lat;
        run_word('0, 0, '0, lat);
        check("R6 zero word latency", lat, 1);
        run_word('1, 0, '0, lat);
        run_word({1'b1, {(WIDTH-1){1'b0}}}, 0, '0, lat);
        run_word(16'h00F0, 0, '0, lat);
    endtask

    task automatic t_sweep();
        int lat, prev = 0;
        for (int i = 0; i < WIDTH; i++) begin
            run_word(WIDTH'(1) << i, 0, '0, lat);
            check("R5 latency grows with top bit", int'(lat > prev), 1);
            prev = lat;
        end
    endtask

    task automatic t_intrude();
        int lat;
        // R9: mid-run start with a different word must not disturb the run
        run_word(16'h8001, 1, 16'h0003, lat);
        check("R9 intruding start ignored", lat, 2*WIDTH + 1);
    endtask

    task automatic t_random();
        logic [WIDTH-1:0] lfsr = 16'hACE1;
        int lat;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[WIDTH-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // R3: back-to-back runs, each result from its own word only
            run_word(lfsr, 0, '0, lat);
        end
    endtask

    initial begin
        t_reset();
        t_idle();
        t_corners();
        t_sweep();
        t_intrude();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule